// File: doc/BRIEF.md
# Slot-Timed Transfer Interrupt Controller

This block paces a microcontroller that services per-slot data registers in a serial frame. It counts data-clock strobes inside a frame of time slots, and the frame-sync pulse restarts the count. Each of four channels has a configurable time slot, and the channel raises a transfer interrupt a short delay after that slot ends. The controller must acknowledge that interrupt before a deadline. The deadline is placed just before a second, separately selected slot. If the acknowledge is missing at the deadline, the channel raises an overflow interrupt instead.

Software uses a small register port. It programs one configuration word per channel: the transfer slot, the deadline slot and a delay-mode bit. It also writes a mask register and sets acknowledge bits. A read strobe returns all pending interrupt bits and clears them. The pending bits that are not masked are ORed into one registered interrupt line. The default frame is 32 slots of 8 bit-clocks, and each bit-clock is 2 data-clock strobes. That gives 512 strobe ticks per frame.

Top module: `stic_top`

## Requirements
- R1: The tick counter is 0 after a cycle with `fsync` high. Each `dcl_en` strobe without `fsync` advances it by one, and it wraps from 511 to 0. Tick k is the strobe seen while the counter holds k.
- R2: When a channel's delay bit is 0, its transfer point is tick ((tr_slot+1)*16 + 4) mod 512. If the channel's transfer mask bit is clear, that strobe sets its transfer status bit.
- R3: When a channel's delay bit is 1, its transfer point is tick ((tr_slot+1)*16 + 2) mod 512.
- R4: A channel's deadline is tick (ov_slot*16 - 2) mod 512 with the delay bit at 0, and tick ov_slot*16 with the delay bit at 1. At the deadline, the overflow status bit is set when three conditions hold: the overflow mask bit is clear, the acknowledge bit is 0, and the channel is armed (see R9).
- R5: Writing address 5 sets the acknowledge bit of every channel c for which data bit c is 1. A channel whose acknowledge bit is set at its deadline raises no overflow.
- R6: At each transfer point of a channel, its acknowledge bit is cleared, even when the transfer is masked.
- R7: Mask register (address 4) bit c masks the transfer interrupt of channel c, and bit 4+c masks its overflow interrupt. A masked bit is never set. The mask resets to all ones.
- R8: When a channel's transfer is masked but its overflow is not, the deadline checks only that channel's acknowledge bit.
- R9: When both bits of a channel are unmasked, the channel is armed by each raised transfer interrupt and disarmed at each deadline. An unarmed deadline raises no overflow.
- R10: A cycle with `rd_en` high loads the pending bits into `rd_data` on the next edge and clears them. A bit raised in that same cycle stays pending.
- R11: `irq` is high exactly when some pending bit is unmasked. It reflects the status and mask that follow each clock edge.
- R12: Status layout: bit c is the transfer bit of channel c and bit 4+c is its overflow bit. Configuration word (addresses 0 to 3): tr_slot in bits 4:0, ov_slot in bits 9:5, delay bit in bit 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame-sync pulse, restarts the tick count |
| dcl_en | input | 1 | One-cycle data-clock strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for writes |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Status read-and-clear strobe |
| rd_data | output | 8 | Status captured by the last read |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
The bench sweeps the slot positions so that transfer points and deadlines wrap across the frame boundary, for example slot 31 and deadline slot 0. A design that computes the wrap wrongly would never fire those channels, or would fire them a frame late. It runs channels with a masked transfer and an unmasked overflow. A design that ties the two masks together, or that still requires arming, would then report no overflow at all. It varies the acknowledge pattern from frame to frame to catch an acknowledge that is never cleared at the transfer point, since such a design would hide every later overflow. It also restarts the frame in the middle of the count, which exposes a counter that ignores the sync pulse, and it reads the status after bursts of activity, which shows lost or stale bits.

// File: rtl/stic_pkg.sv
package stic_pkg;
  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CFG,
    SEL_MASK,
    SEL_ACK
  } reg_sel_e;
endpackage

// File: rtl/stic_frame_ctr.sv
module stic_frame_ctr #(
  parameter int TICKS  = 512,
  parameter int TICK_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync,
  input  logic              dcl_en,
  output logic [TICK_W-1:0] tick
);
  localparam logic [TICK_W-1:0] LAST = TICK_W'(TICKS - 1);

  always_ff @(posedge clk) begin
    if (rst || fsync) tick <= '0;
    else if (dcl_en)  tick <= (tick == LAST) ? '0 : tick + 1'b1;
  end
endmodule

// File: rtl/stic_chan_timing.sv
module stic_chan_timing #(
  parameter int SLOT_W = 5,
  parameter int TICK_W = 9,
  parameter int TICKS  = 512,
  parameter int SPT    = 16,
  parameter int DPB    = 2
) (
  input  logic [SLOT_W-1:0] tr_slot,
  input  logic [SLOT_W-1:0] ov_slot,
  input  logic              dps,
  input  logic [TICK_W-1:0] tick,
  input  logic              step,
  output logic              tr_hit,
  output logic              dl_hit
);
  localparam int EW = TICK_W + 2;
  localparam logic [EW-1:0] E_TICKS = EW'(TICKS);

  logic [EW-1:0] ev_raw, dl_raw, ev_t, dl_t;

  always_comb begin
    ev_raw = (EW'(tr_slot) + EW'(1)) * EW'(SPT) + (dps ? EW'(DPB) : EW'(2 * DPB));
    dl_raw = EW'(ov_slot) * EW'(SPT) + E_TICKS - (dps ? EW'(0) : EW'(DPB));
    ev_t   = (ev_raw >= E_TICKS) ? ev_raw - E_TICKS : ev_raw;
    dl_t   = (dl_raw >= E_TICKS) ? dl_raw - E_TICKS : dl_raw;
    tr_hit = step && (tick == ev_t[TICK_W-1:0]);
    dl_hit = step && (tick == dl_t[TICK_W-1:0]);
  end
endmodule

// File: rtl/stic_irq_core.sv
module stic_irq_core #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   tr_hit,
  input  logic [N-1:0]   dl_hit,
  input  logic [2*N-1:0] mask_q,
  input  logic [2*N-1:0] mask_d,
  input  logic [N-1:0]   ack_set,
  input  logic           rd_en,
  output logic [2*N-1:0] st,
  output logic [N-1:0]   ack,
  output logic [2*N-1:0] rd_data,
  output logic           irq
);
  logic [N-1:0]   armed, tr_raise, ov_raise, ack_n, armed_n;
  logic [2*N-1:0] st_n;

  always_comb begin
    tr_raise = tr_hit & ~mask_q[N-1:0];
    ov_raise = dl_hit & ~mask_q[2*N-1:N] & ~ack & (mask_q[N-1:0] | armed);
    ack_n    = (ack & ~tr_hit) | ack_set;
    armed_n  = tr_raise | (armed & ~dl_hit);
    st_n     = (rd_en ? '0 : st) | {ov_raise, tr_raise};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= '0;
      ack     <= '0;
      armed   <= '0;
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      st    <= st_n;
      ack   <= ack_n;
      armed <= armed_n;
      irq   <= |(st_n & ~mask_d);
      if (rd_en) rd_data <= st;
    end
  end
endmodule

// File: rtl/stic_top.sv
module stic_top #(
  parameter int NUM_CH        = 4,
  parameter int SLOTS         = 32,
  parameter int BITS_PER_SLOT = 8,
  parameter int DCL_PER_BIT   = 2,
  parameter int DW            = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fsync,
  input  logic                      dcl_en,
  input  logic                      wr_en,
  input  logic [$clog2(NUM_CH+2)-1:0] addr,
  input  logic [DW-1:0]             wr_data,
  input  logic                      rd_en,
  output logic [2*NUM_CH-1:0]       rd_data,
  output logic                      irq
);
  import stic_pkg::*;

  localparam int SLOT_W = $clog2(SLOTS);
  localparam int SPT    = BITS_PER_SLOT * DCL_PER_BIT;
  localparam int TICKS  = SLOTS * SPT;
  localparam int TICK_W = $clog2(TICKS);
  localparam int AW     = $clog2(NUM_CH + 2);
  localparam int CFG_W  = 2 * SLOT_W + 1;

  logic [TICK_W-1:0]  tick;
  logic [CFG_W-1:0]   cfg_q [NUM_CH];
  logic [2*NUM_CH-1:0] mask_q, mask_d, st;
  logic [NUM_CH-1:0]  tr_hit, dl_hit, ack_set, ack;
  logic               step;
  reg_sel_e           sel;

  always_comb begin
    if (!wr_en)                      sel = SEL_NONE;
    else if (addr < AW'(NUM_CH))     sel = SEL_CFG;
    else if (addr == AW'(NUM_CH))    sel = SEL_MASK;
    else if (addr == AW'(NUM_CH+1))  sel = SEL_ACK;
    else                             sel = SEL_NONE;
    mask_d  = (sel == SEL_MASK) ? wr_data[2*NUM_CH-1:0] : mask_q;
    ack_set = (sel == SEL_ACK)  ? wr_data[NUM_CH-1:0]   : '0;
    step    = dcl_en && !fsync;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      for (int c = 0; c < NUM_CH; c++) cfg_q[c] <= '0;
    end else begin
      mask_q <= mask_d;
      for (int c = 0; c < NUM_CH; c++)
        if (sel == SEL_CFG && addr == AW'(c)) cfg_q[c] <= wr_data[CFG_W-1:0];
    end
  end

  stic_frame_ctr #(.TICKS(TICKS), .TICK_W(TICK_W)) u_ctr (
    .clk(clk), .rst(rst), .fsync(fsync), .dcl_en(dcl_en), .tick(tick)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    stic_chan_timing #(
      .SLOT_W(SLOT_W), .TICK_W(TICK_W), .TICKS(TICKS), .SPT(SPT), .DPB(DCL_PER_BIT)
    ) u_tim (
      .tr_slot(cfg_q[g][SLOT_W-1:0]),
      .ov_slot(cfg_q[g][2*SLOT_W-1:SLOT_W]),
      .dps    (cfg_q[g][2*SLOT_W]),
      .tick   (tick),
      .step   (step),
      .tr_hit (tr_hit[g]),
      .dl_hit (dl_hit[g])
    );
  end

  stic_irq_core #(.N(NUM_CH)) u_core (
    .clk(clk), .rst(rst), .tr_hit(tr_hit), .dl_hit(dl_hit),
    .mask_q(mask_q), .mask_d(mask_d), .ack_set(ack_set), .rd_en(rd_en),
    .st(st), .ack(ack), .rd_data(rd_data), .irq(irq)
  );
endmodule

// File: rtl/stic_chk.sv
module stic_chk #(
  parameter int N      = 4,
  parameter int TICK_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              fsync,
  input logic              rd_en,
  input logic [TICK_W-1:0] tick,
  input logic [N-1:0]      tr_hit,
  input logic [N-1:0]      dl_hit,
  input logic [N-1:0]      ack_set,
  input logic [N-1:0]      ack,
  input logic [2*N-1:0]    mask_q,
  input logic [2*N-1:0]    st,
  input logic [2*N-1:0]    rd_data,
  input logic              irq
);
  p_sync_restart_r1: assert property (@(posedge clk) disable iff (rst)
    fsync |=> tick == '0);

  p_ack_covers_r5: assert property (@(posedge clk) disable iff (rst)
    ((st[2*N-1:N] & ~$past(st[2*N-1:N])) & $past(ack)) == '0);

  p_ack_dropped_r6: assert property (@(posedge clk) disable iff (rst)
    (ack & $past(tr_hit & ~ack_set)) == '0);

  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    ((st & ~$past(st)) & $past(mask_q)) == '0);

  p_read_returns_r10: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_data == $past(st));

  p_read_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && tr_hit == '0 && dl_hit == '0) |=> st == '0);

  p_irq_line_r11: assert property (@(posedge clk) disable iff (rst)
    irq == |(st & ~mask_q));
endmodule

bind stic_top stic_chk #(.N(NUM_CH), .TICK_W(TICK_W)) u_chk (
  .clk(clk), .rst(rst), .fsync(fsync), .rd_en(rd_en), .tick(tick),
  .tr_hit(tr_hit), .dl_hit(dl_hit), .ack_set(ack_set), .ack(ack),
  .mask_q(mask_q), .st(st), .rd_data(rd_data), .irq(irq)
);

// File: tb/sim_stic_top.sv
module sim_stic_top;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fsync = 1'b0, dcl_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rd_data;
  logic        irq;

  int n_cmp = 0, n_bad = 0;
  int m_tr[NCH], m_ov[NCH];
  bit m_dps[NCH];
  bit [7:0] m_mask;
  bit [3:0] m_ack, m_armed, m_trs, m_ovs;

  always #5 clk = ~clk;

  stic_top u0 (
    .clk(clk), .rst(rst), .fsync(fsync), .dcl_en(dcl_en), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ev_tick(int c);
    return ((m_tr[c] + 1) * 16 + (m_dps[c] ? 2 : 4)) % 512;
  endfunction

  function automatic int dl_tick(int c);
    return (m_ov[c] * 16 + 512 - (m_dps[c] ? 0 : 2)) % 512;
  endfunction

  function automatic bit exp_irq();
    return |({m_ovs, m_trs} & ~m_mask);
  endfunction

  task automatic edge1();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; addr = 3'(a); wr_data = 16'(d);
    edge1();
    wr_en = 1'b0;
    if (a < NCH) begin
      m_tr[a] = d & 31; m_ov[a] = (d >> 5) & 31; m_dps[a] = d[10];
    end else if (a == NCH) m_mask = 8'(d);
    else m_ack |= 4'(d);
  endtask

  task automatic rd_chk(string req);
    rd_en = 1'b1;
    edge1();
    rd_en = 1'b0;
    chk(req, rd_data, {m_ovs, m_trs});
    m_ovs = '0; m_trs = '0;
    chk("R10", irq, 0);
  endtask

  task automatic fs();
    fsync = 1'b1;
    edge1();
    fsync = 1'b0;
  endtask

  task automatic step_dcl(int k, string req);
    bit [3:0] trh, dlh, trr, ovr;
    dcl_en = 1'b1;
    edge1();
    dcl_en = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      trh[c] = (ev_tick(c) == k);
      dlh[c] = (dl_tick(c) == k);
    end
    trr = trh & ~m_mask[3:0];
    ovr = dlh & ~m_mask[7:4] & ~m_ack & (m_mask[3:0] | m_armed);
    m_ack   = m_ack & ~trh;
    m_armed = trr | (m_armed & ~dlh);
    m_trs |= trr;
    m_ovs |= ovr;
    chk(req, irq, int'(exp_irq()));
  endtask

  task automatic run_frame(string req, bit [3:0] ackpol, bit sync, string rreq);
    if (sync) fs();
    for (int k = 0; k < 512; k++) begin
      step_dcl(k, req);
      for (int c = 0; c < NCH; c++)
        if (ackpol[c] && ev_tick(c) == k) wr(5, 1 << c);
      if (k % 128 == 127) rd_chk(rreq);
    end
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    m_mask = 8'hFF; m_ack = '0; m_armed = '0; m_trs = '0; m_ovs = '0;
    for (int c = 0; c < NCH; c++) begin m_tr[c] = 0; m_ov[c] = 0; m_dps[c] = 0; end
    repeat (3) edge1();
    rst = 1'b0;
    edge1();
    chk("R11 reset", irq, 0);
    rd_chk("R10 reset");

    // R2: channel 0, slot 3, delay bit 0; R12 bit position of transfer 0
    wr(0, 3 | (10 << 5));
    wr(4, 8'hFE);
    run_frame("R2", 4'b0000, 1'b1, "R12");
    // R3: channel 1, slot 5, delay bit 1
    wr(4, 8'hFF); rd_chk("R10");
    wr(1, 5 | (6 << 5) | (1 << 10));
    wr(4, 8'hFD);
    run_frame("R3", 4'b0000, 1'b1, "R12");
    // R4: overflow without acknowledge, both channels 0 and 1
    wr(4, 8'hCC);
    run_frame("R4", 4'b0000, 1'b1, "R4");
    run_frame("R4", 4'b0000, 1'b1, "R12");
    // R5: acknowledge in time suppresses overflow
    run_frame("R5", 4'b0011, 1'b1, "R5");
    // R8: channel 3 transfer masked, overflow unmasked, slot 20 delay 1
    wr(3, 7 | (20 << 5) | (1 << 10));
    wr(4, 8'h7F);
    run_frame("R8", 4'b0000, 1'b1, "R8");
    run_frame("R8", 4'b1000, 1'b1, "R8");
    // R9: channel 2 wraps, transfer at slot 31, deadline at slot 0
    wr(2, 31 | (0 << 5));
    wr(4, 8'hBB);
    run_frame("R9", 4'b0000, 1'b1, "R9");
    run_frame("R9", 4'b0000, 1'b1, "R9");
    // R1: frame continues by wrap without sync, then restart mid-frame
    run_frame("R1", 4'b0100, 1'b0, "R1");
    for (int k = 0; k < 200; k++) step_dcl(k, "R1");
    run_frame("R1", 4'b0000, 1'b1, "R1");
    // R7: all masked
    wr(4, 8'hFF);
    rd_chk("R7");
    run_frame("R7", 4'b1111, 1'b1, "R7");
    // R6 and sweep over configurations, masks and acknowledge patterns
    for (int f = 0; f < 16; f++) begin
      for (int c = 0; c < NCH; c++)
        wr(c, ((f * 7 + c * 9) % 32) | (((f * 5 + c * 13 + 31) % 32) << 5) | (((f >> c) & 1) << 10));
      wr(4, (f * 37) & 8'hFF);
      run_frame("R6", 4'(f ^ (f >> 1)), 1'b1, "R10");
    end
    rd_chk("R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule